// File: doc/BRIEF.md
# Watchpoint Address Register Bank

This block holds sixteen data-address registers, one for each hardware watchpoint, and pairs each one with an address comparator. A debug agent writes an entry through a single write port that takes an entry index and a 64-bit value. A read port returns the selected entry in the same 64-bit layout. Every cycle, each entry compares the address of the current data access with its stored value. It raises its own match bit when that entry's enable input is high and the compared address bits are equal.

Only the compared address field is stored. The two lowest bits are hardwired to zero. All bits above the compared field are rebuilt on readback as copies of the field's top bit. A build parameter selects the address width. When it is off, the compared field is bits [48:2]. When it is on, the field is bits [52:2]. Enable inputs come straight from the companion control logic. Access-type filtering, byte selection and exception generation are handled outside this block.

Top module: `wpt_addr_bank`

## Requirements
- R1: When wr_en_i is high at a rising clock edge, entry wr_idx_i (0 to 15) stores wr_data_i. From the next cycle on, that value is returned on rd_data_o whenever rd_idx_i selects that entry.
- R2: Bits [1:0] of rd_data_o always read as zero, whatever value was written to them.
- R3: The compared field is bits [48:2] when LARGE_VA is 0 and bits [52:2] when LARGE_VA is 1. A difference at bit 50 alone therefore changes the match result only when LARGE_VA is 1.
- R4: On readback, every bit above the compared field is a copy of the field's most significant bit (bit 48 or bit 52), not the value that was written to it.
- R5: Bit 2 is stored and compared like every other bit of the compared field.
- R6: match_o[k] is high exactly when ent_en_i[k] is high and addr_i equals entry k over the compared field. Address bits above the field and bits [1:0] have no effect. With ent_en_i[k] low, match_o[k] is low.
- R7: match_o is combinational. It follows a change on addr_i or ent_en_i in the same cycle, and it follows a write from the cycle after the write edge.
- R8: A write changes only the indexed entry. All other entries keep their values.
- R9: With wr_en_i low, wr_idx_i and wr_data_i change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 4 | Entry index to write |
| wr_data_i | input | 64 | Value to write |
| rd_idx_i | input | 4 | Entry index to read |
| rd_data_o | output | 64 | Readback of the selected entry |
| addr_i | input | 64 | Data address to compare |
| ent_en_i | input | 16 | Per-entry compare enable |
| match_o | output | 16 | Per-entry match |

## Verification
Two instances run side by side on identical stimulus, one with the narrow address field and one with the wide field. Addresses that differ only at bit 50 produce different match results in the two instances, which separates the two field widths.

Other stimuli separate the remaining behaviour:
- Compare addresses that equal a stored value but carry corrupted upper bits and low bits show that those bits are ignored.
- Single-bit flips at bit 2 and at the top of the compared field show that the compare is exact at both ends.
- Written values with non-canonical upper bits and set low bits show the readback rebuilding of those bits.
- Interleaved writes, idle cycles with live write data, and enable patterns show entry isolation and gating.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned CMP_LO = 2;

  function automatic int unsigned cmp_hi(bit large_va);
    return large_va ? 52 : 48;
  endfunction
endpackage

// File: rtl/wpt_store.sv
module wpt_store #(
  parameter int unsigned NUM_ENT = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned HI      = 48,
  parameter int unsigned LO      = 2,
  localparam int unsigned FW     = HI - LO + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [FW-1:0]                 wr_fld_i,
  output logic [NUM_ENT-1:0][FW-1:0]    ent_q_o
);
  for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
    logic [FW-1:0] fld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            fld_q <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(k)))            fld_q <= wr_fld_i;
    end
    assign ent_q_o[k] = fld_q;
  end
endmodule

// File: rtl/wpt_cmp.sv
module wpt_cmp #(
  parameter int unsigned NUM_ENT = 16,
  parameter int unsigned FW      = 47
) (
  input  logic [NUM_ENT-1:0][FW-1:0] ent_i,
  input  logic [FW-1:0]              addr_fld_i,
  input  logic [NUM_ENT-1:0]         en_i,
  output logic [NUM_ENT-1:0]         hit_o
);
  for (genvar k = 0; k < NUM_ENT; k++) begin : g_cmp
    assign hit_o[k] = en_i[k] && (ent_i[k] == addr_fld_i);
  end
endmodule

// File: rtl/wpt_rdfmt.sv
module wpt_rdfmt #(
  parameter int unsigned NUM_ENT = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned HI      = 48,
  parameter int unsigned LO      = 2,
  localparam int unsigned FW     = HI - LO + 1,
  localparam int unsigned SX_W   = DATA_W - 1 - HI
) (
  input  logic [NUM_ENT-1:0][FW-1:0] ent_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic [DATA_W-1:0]          data_o
);
  logic [FW-1:0] sel;
  assign sel    = ent_i[idx_i];
  // upper bits rebuilt as sign copies, low bits hardwired zero
  assign data_o = {{SX_W{sel[FW-1]}}, sel, {LO{1'b0}}};
endmodule

// File: rtl/wpt_addr_bank.sv
module wpt_addr_bank
  import wpt_pkg::*;
#(
  parameter int unsigned NUM_ENT  = 16,
  parameter bit          LARGE_VA = 1'b0,
  localparam int unsigned IDX_W   = $clog2(NUM_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [DATA_W-1:0]  addr_i,
  input  logic [NUM_ENT-1:0] ent_en_i,
  output logic [NUM_ENT-1:0] match_o
);
  localparam int unsigned HI = cmp_hi(LARGE_VA);
  localparam int unsigned FW = HI - CMP_LO + 1;

  logic [NUM_ENT-1:0][FW-1:0] ent_q;

  wpt_store #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .HI(HI), .LO(CMP_LO)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_fld_i (wr_data_i[HI:CMP_LO]),
    .ent_q_o  (ent_q)
  );

  wpt_cmp #(.NUM_ENT(NUM_ENT), .FW(FW)) u_cmp (
    .ent_i      (ent_q),
    .addr_fld_i (addr_i[HI:CMP_LO]),
    .en_i       (ent_en_i),
    .hit_o      (match_o)
  );

  wpt_rdfmt #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .DATA_W(DATA_W), .HI(HI), .LO(CMP_LO)) u_rd (
    .ent_i  (ent_q),
    .idx_i  (rd_idx_i),
    .data_o (rd_data_o)
  );
endmodule

// File: rtl/wpt_addr_bank_chk.sv
module wpt_addr_bank_chk
  import wpt_pkg::*;
#(
  parameter int unsigned NUM_ENT  = 16,
  parameter bit          LARGE_VA = 1'b0,
  localparam int unsigned IDX_W   = $clog2(NUM_ENT),
  localparam int unsigned HI      = cmp_hi(LARGE_VA)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [IDX_W-1:0]   wr_idx_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [IDX_W-1:0]   rd_idx_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic [DATA_W-1:0]  addr_i,
  input logic [NUM_ENT-1:0] ent_en_i,
  input logic [NUM_ENT-1:0] match_o
);
  a_r2_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1:0] == 2'b00);

  a_r4_sign_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:HI] == {(DATA_W-HI){rd_data_o[HI]}});

  a_r6_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o & ~ent_en_i) == '0);

  a_r1_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((rd_idx_i != $past(wr_idx_i)) ||
                 (rd_data_o[HI:CMP_LO] == $past(wr_data_i[HI:CMP_LO]))));

  a_r7_match_vs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_en_i[rd_idx_i] |-> (match_o[rd_idx_i] == (addr_i[HI:CMP_LO] == rd_data_o[HI:CMP_LO])));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && (rd_idx_i == $past(rd_idx_i))) |-> $stable(rd_data_o));
endmodule

bind wpt_addr_bank wpt_addr_bank_chk #(.NUM_ENT(NUM_ENT), .LARGE_VA(LARGE_VA)) u_chk (.*);

// File: tb/sim_wpt_addr_bank.sv
module sim_wpt_addr_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [63:0] addr = '0;
  logic [15:0] en = '0;
  logic [63:0] rd0, rd1;
  logic [15:0] m0, m1;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R6";

  logic [63:0] mem [16];
  bit          seen [16];

  always #5 clk = ~clk;

  wpt_addr_bank #(.LARGE_VA(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd0), .addr_i(addr), .ent_en_i(en), .match_o(m0));

  wpt_addr_bank #(.LARGE_VA(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd1), .addr_i(addr), .ent_en_i(en), .match_o(m1));

  function automatic logic [63:0] exp_rd(logic [63:0] v, int hi);
    logic [63:0] r = v;
    r[1:0] = 2'b00;
    for (int b = hi + 1; b < 64; b++) r[b] = v[hi];
    return r;
  endfunction

  function automatic bit same_fld(logic [63:0] a, logic [63:0] b, int hi);
    for (int i = 2; i <= hi; i++) if (a[i] !== b[i]) return 1'b0;
    return 1'b1;
  endfunction

  // reference model state update
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && wr_en) begin
      mem[wr_idx]  <= wr_data;
      seen[wr_idx] <= 1'b1;
    end
  end

  task automatic cmp_dut(logic [63:0] rd, logic [15:0] m, int hi, string nm);
    logic [15:0] exp_m = '0;
    logic [15:0] msk = '0;
    if (seen[rd_idx]) begin
      tests++;
      if (rd !== exp_rd(mem[rd_idx], hi)) begin
        fails++;
        $display("FAIL %s %s read idx %0d: got %h exp %h", tag, nm, rd_idx, rd, exp_rd(mem[rd_idx], hi));
      end
    end
    for (int k = 0; k < 16; k++) begin
      if (!en[k]) msk[k] = 1'b1;
      else if (seen[k]) begin
        msk[k]   = 1'b1;
        exp_m[k] = same_fld(mem[k], addr, hi);
      end
    end
    tests++;
    if (((m ^ exp_m) & msk) != '0) begin
      fails++;
      $display("FAIL %s %s match: got %h exp %h mask %h", tag, nm, m, exp_m, msk);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp_dut(rd0, m0, 48, "narrow");
    cmp_dut(rd1, m1, 52, "wide");
  end

  always @(posedge clk) if (cyc > 20000) begin
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic drive(bit we, int wi, logic [63:0] wd, int ri, logic [63:0] a, logic [15:0] e);
    @(posedge clk);
    #2;
    wr_en = we; wr_idx = 4'(wi); wr_data = wd; rd_idx = 4'(ri); addr = a; en = e;
  endtask

  initial begin
    logic [63:0] v;
    for (int k = 0; k < 16; k++) seen[k] = 1'b0;
    #12;
    // R6: reset state, enables low give no match
    tests++;
    if (m0 !== 16'h0 || m1 !== 16'h0) begin
      fails++;
      $display("FAIL R6 reset match got %h/%h exp 0000", m0, m1);
    end
    #20 rst_n = 1'b1;

    // R1: fill every entry and read each back
    tag = "R1";
    for (int k = 0; k < 16; k++) drive(1, k, {$urandom, $urandom}, k, '0, '0);
    for (int k = 0; k < 16; k++) drive(0, 0, '0, k, '0, '0);

    // R2: low bits set on write
    tag = "R2";
    drive(1, 3, 64'h0000_1234_5678_9ABF, 3, '0, '0);
    drive(0, 0, '0, 3, '0, '0);

    // R4: non-canonical upper bits, both polarities of the top field bit
    tag = "R4";
    drive(1, 5, 64'h5A00_0000_0000_1000, 5, '0, '0);
    drive(1, 6, 64'h00FF_8000_0000_2000, 6, '0, '0);
    drive(1, 7, 64'hFFF0_0000_0000_0004, 7, '0, '0);
    for (int k = 5; k < 8; k++) drive(0, 0, '0, k, '0, '0);

    // R5: bit 2 stored and compared
    tag = "R5";
    drive(1, 9, 64'h0000_0000_0000_0004, 9, '0, 16'h0200);
    drive(0, 0, '0, 9, 64'h0000_0000_0000_0004, 16'h0200);
    drive(0, 0, '0, 9, 64'h0000_0000_0000_0000, 16'h0200);

    // R3: difference at bit 50 only
    tag = "R3";
    drive(1, 10, 64'h0000_0000_4000_0000, 10, '0, '0);
    drive(0, 0, '0, 10, 64'h0004_0000_4000_0000, 16'h0400);
    drive(0, 0, '0, 10, 64'h0000_0000_4000_0000, 16'h0400);

    // R6: upper and low address bits ignored, enable gating
    tag = "R6";
    for (int k = 0; k < 16; k++) begin
      v = mem[k];
      drive(0, 0, '0, k, {11'h5A5, v[52:2], 2'b11}, 16'hFFFF);
      drive(0, 0, '0, k, v ^ 64'h0001_0000_0000_0000, 16'hFFFF);
      drive(0, 0, '0, k, v, 16'h0000);
      drive(0, 0, '0, k, v, 16'(1) << k);
    end

    // R7: address changes every cycle, then match after a write edge
    tag = "R7";
    drive(1, 12, 64'h0000_0ABC_DEF0_1230, 12, 64'h0000_0ABC_DEF0_1230, 16'h1000);
    drive(0, 0, '0, 12, 64'h0000_0ABC_DEF0_1230, 16'h1000);
    drive(0, 0, '0, 12, 64'h0000_0ABC_DEF0_1234, 16'h1000);
    drive(0, 0, '0, 12, 64'h0000_0ABC_DEF0_1230, 16'h1000);

    // R8: write one entry, read all others
    tag = "R8";
    drive(1, 14, 64'hFFFF_FFFF_FFFF_FFFC, 14, '0, 16'hFFFF);
    for (int k = 0; k < 16; k++) drive(0, 0, '0, k, 64'hFFFF_FFFF_FFFF_FFFC, 16'hFFFF);

    // R9: live write data with strobe low
    tag = "R9";
    for (int k = 0; k < 16; k++) drive(0, k, ~mem[k], k, '0, '0);
    for (int k = 0; k < 16; k++) drive(0, 0, '0, k, mem[k], 16'hFFFF);

    // mixed traffic
    tag = "R1";
    for (int i = 0; i < 200; i++) begin
      int wi = $urandom_range(0, 15);
      int ri = $urandom_range(0, 15);
      v = (i % 3 == 0) ? mem[ri] : {$urandom, $urandom};
      drive(bit'($urandom_range(0, 1)), wi, {$urandom, $urandom}, ri, v, 16'($urandom));
    end
    drive(0, 0, '0, 0, '0, '0);
    @(negedge clk);
    #1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule